// File: doc/BRIEF.md
# Count strobe generator with prescaler and input glitch filter

This block makes the count-enable strobe that advances a compare timer. It works in one clock domain. Four clock-enable strobes stand in for four possible timebases, and a 2-bit select picks one of them. A shared 4-bit value `v` then sets up one of two paths. In time-counter mode, a power-of-two prescaler divides the selected ticks. In pulse-counter mode, a glitch filter passes a change on the pulse input only after the new level has stayed stable for enough selected ticks. A bypass bit skips the prescaler or the filter.

In time-counter mode each prescaler period, or each selected tick under bypass, gives one count. In pulse-counter mode each accepted rising level of the pulse input gives one count. When the enable input is low, every internal stage goes back to idle. The pulse input is taken to be synchronous to `clk_i`.

Top module: `count_strobe_gen`

## Requirements
- R1: `tick_sel_i` = k selects bit k of `tick_i` as the timebase. The other three bits have no effect on `count_en_o`.
- R2: In time mode with `bypass_i`=0, `count_en_o` pulses for one cycle in the cycle after every 2^(v+1)-th selected tick. `v`=0 divides by 2 and `v`=15 divides by 65536. Two pulses are never adjacent.
- R3: In time mode with `bypass_i`=1, every selected tick gives a one-cycle `count_en_o` in the next cycle. With no selected tick, no count is produced.
- R4: In pulse mode with `bypass_i`=0, a new level on `pulse_i` is accepted only after it has been sampled on 2^v consecutive selected ticks. Each accepted change from 0 to 1 gives one `count_en_o` pulse in the next cycle. With `v`=15 this takes 32768 ticks.
- R5: If `pulse_i` is seen at the already accepted level on a selected tick, the filter count starts again from zero.
- R6: In pulse mode, `v`=0 behaves as a filter of 2 stable ticks.
- R7: In pulse mode with `bypass_i`=1, every rising edge of `pulse_i` gives one count in the next cycle, whatever `tick_i` does.
- R8: While `enable_i`=0, `count_en_o` is 0 and the prescaler, the filter count and the accepted level (which becomes 0) are cleared. A partial prescaler period is therefore lost.
- R9: After reset, `count_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Timer enabled; low returns all stages to idle |
| pulse_mode_i | input | 1 | 0: time-counter mode, 1: pulse-counter mode |
| bypass_i | input | 1 | Skip prescaler (time mode) or filter (pulse mode) |
| tick_sel_i | input | 2 | Index of the timebase strobe |
| div_val_i | input | 4 | Shared prescaler/filter value v |
| tick_i | input | 4 | Clock-enable strobes, one per timebase |
| pulse_i | input | 1 | Pulse input, active high |
| count_en_o | output | 1 | One-cycle count-enable strobe |

## Verification
The bench uses the default parameters: four timebases and a 4-bit value, which gives a 16-bit internal counter. Because a timebase can be driven high on every cycle, both extreme settings can be run in full within the cycle budget. These are divide-by-65536 and the 32768-tick filter, each checked one tick short of its period and then at the exact tick. The four timebases toggle at different rates, so a wrong selection changes the count that is observed.

// File: rtl/count_strobe_pkg.sv
package count_strobe_pkg;
  typedef enum logic {
    MODE_TIME  = 1'b0,
    MODE_PULSE = 1'b1
  } cnt_mode_e;

  localparam int unsigned DEF_NUM_SRC = 4;
  localparam int unsigned DEF_VAL_W   = 4;
endpackage

// File: rtl/tick_select.sv
module tick_select #(
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign hit[k] = tick_i[k] && (sel_i == SEL_W'(k));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned VAL_W = 4,
  localparam int unsigned CNT_W = 1 << VAL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [VAL_W-1:0] val_i,
  output logic             strobe_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             wrap;

  // period 2^(v+1): last index is a mask of v+1 ones
  assign last     = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(val_i));
  assign wrap     = cnt_q >= last;
  assign strobe_o = run_i && tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (tick_i)     cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  a_r2_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  a_r8_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pulse_filter.sv
module pulse_filter #(
  parameter int unsigned VAL_W = 4,
  localparam int unsigned CNT_W = 1 << VAL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bypass_i,
  input  logic             tick_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic             pin_i,
  output logic             rise_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need_m1;
  logic             acc_q;
  logic             differ;
  logic             accept;

  // 2^v stable ticks; v=0 clamps to 2
  assign need_m1 = (val_i == '0) ? CNT_W'(1) : ({CNT_W{1'b1}} >> (CNT_W - int'(val_i)));
  assign differ  = pin_i != acc_q;
  assign accept  = bypass_i ? differ : (tick_i && differ && cnt_q >= need_m1);
  assign rise_o  = run_i && accept && pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (accept) begin
      cnt_q <= '0;
      acc_q <= pin_i;
    end else if (tick_i && !bypass_i) begin
      cnt_q <= differ ? cnt_q + 1'b1 : '0;
    end
  end

  a_r4_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bypass_i && !tick_i) |=> $stable(acc_q));

  a_r5_restart_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bypass_i && tick_i && (pin_i == acc_q)) |=> cnt_q == '0);

  a_r8_level_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !acc_q);
endmodule

// File: rtl/count_strobe_gen.sv
module count_strobe_gen
  import count_strobe_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_NUM_SRC,
  parameter int unsigned VAL_W   = DEF_VAL_W,
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               pulse_mode_i,
  input  logic               bypass_i,
  input  logic [SEL_W-1:0]   tick_sel_i,
  input  logic [VAL_W-1:0]   div_val_i,
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic               pulse_i,
  output logic               count_en_o
);
  cnt_mode_e mode;
  logic      sel_tick;
  logic      presc_run;
  logic      filt_run;
  logic      presc_stb;
  logic      filt_rise;
  logic      count_d;
  logic      count_q;

  assign mode      = cnt_mode_e'(pulse_mode_i);
  assign presc_run = enable_i && (mode == MODE_TIME) && !bypass_i;
  assign filt_run  = enable_i && (mode == MODE_PULSE);

  tick_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .sel_i  (tick_sel_i),
    .tick_i (tick_i),
    .tick_o (sel_tick)
  );

  tick_prescaler #(.VAL_W(VAL_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (presc_run),
    .tick_i   (sel_tick),
    .val_i    (div_val_i),
    .strobe_o (presc_stb)
  );

  pulse_filter #(.VAL_W(VAL_W)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (filt_run),
    .bypass_i (bypass_i),
    .tick_i   (sel_tick),
    .val_i    (div_val_i),
    .pin_i    (pulse_i),
    .rise_o   (filt_rise)
  );

  always_comb begin
    count_d = 1'b0;
    if (enable_i) begin
      if (mode == MODE_PULSE) count_d = filt_rise;
      else if (bypass_i)      count_d = sel_tick;
      else                    count_d = presc_stb;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= 1'b0;
    else         count_q <= count_d;
  end

  assign count_en_o = count_q;

  a_r8_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !count_en_o);

  a_r3_no_tick_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !pulse_mode_i && !sel_tick) |=> !count_en_o);

  a_r7_bypass_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && pulse_mode_i && bypass_i && !pulse_i) |=> !count_en_o);
endmodule

// File: tb/count_strobe_gen_tb.sv
module count_strobe_gen_tb;
  typedef struct packed {
    logic        byp;
    logic [1:0]  sel;
    logic [3:0]  val;
    logic [31:0] n;
    logic [31:0] exp;
  } vec_t;

  // time mode; source k ticks when c % (k+1) == 0
  localparam vec_t VECS[8] = '{
    '{1'b1, 2'd0, 4'd0, 32'd20,  32'd20},  // R3
    '{1'b1, 2'd2, 4'd0, 32'd30,  32'd10},  // R3 R1
    '{1'b1, 2'd1, 4'd0, 32'd10,  32'd5},   // R3 default cfg
    '{1'b0, 2'd0, 4'd0, 32'd20,  32'd10},  // R2
    '{1'b0, 2'd1, 4'd0, 32'd40,  32'd10},  // R2 R1
    '{1'b0, 2'd0, 4'd2, 32'd64,  32'd8},   // R2
    '{1'b0, 2'd3, 4'd3, 32'd256, 32'd4},   // R2 R1
    '{1'b0, 2'd0, 4'd1, 32'd7,   32'd1}    // R2 partial
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       pulse_mode_i = 1'b0;
  logic       bypass_i = 1'b1;
  logic [1:0] tick_sel_i = 2'd1;
  logic [3:0] div_val_i = 4'd0;
  logic [3:0] tick_i = 4'd0;
  logic       pulse_i = 1'b0;
  logic       count_en_o;

  int n_chk = 0;
  int n_bad = 0;
  int seen = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;

  count_strobe_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .pulse_mode_i(pulse_mode_i),
    .bypass_i(bypass_i), .tick_sel_i(tick_sel_i), .div_val_i(div_val_i),
    .tick_i(tick_i), .pulse_i(pulse_i), .count_en_o(count_en_o)
  );

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (count_en_o) seen <= seen + 1;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // n cycles of rate-staggered ticks, pulse held at lvl
  task automatic drive(input logic lvl, input int n, input logic ticks_on);
    for (int c = 0; c < n; c++) begin
      @(negedge clk_i);
      pulse_i = lvl;
      for (int k = 0; k < 4; k++) tick_i[k] = ticks_on && (c % (k + 1) == 0);
    end
    @(negedge clk_i);
    tick_i = '0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic start(input logic pm, input logic byp, input logic [1:0] sel, input logic [3:0] v);
    @(negedge clk_i);
    enable_i = 1'b0;
    pulse_i = 1'b0;
    tick_i = '0;
    pulse_mode_i = pm;
    bypass_i = byp;
    tick_sel_i = sel;
    div_val_i = v;
    @(negedge clk_i);
    enable_i = 1'b1;
    seen = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      if (cyc > 190000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected < 190000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset", int'(count_en_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 after release", int'(count_en_o), 0);

    for (int i = 0; i < 8; i++) begin
      start(1'b0, VECS[i].byp, VECS[i].sel, VECS[i].val);
      drive(1'b0, int'(VECS[i].n), 1'b1);
      check($sformatf("R1/R2/R3 vec %0d", i), seen, int'(VECS[i].exp));
    end

    // R2 divide-by-65536 edge
    start(1'b0, 1'b0, 2'd0, 4'd15);
    drive(1'b0, 65535, 1'b1);
    check("R2 v15 one short", seen, 0);
    drive(1'b0, 1, 1'b1);
    check("R2 v15 full period", seen, 1);

    // R8 disable drops partial period
    start(1'b0, 1'b0, 2'd0, 4'd2);
    drive(1'b0, 7, 1'b1);
    @(negedge clk_i);
    enable_i = 1'b0;
    tick_i = 4'hf;
    @(negedge clk_i);
    check("R8 off output", int'(count_en_o), 0);
    tick_i = '0;
    enable_i = 1'b1;
    drive(1'b0, 7, 1'b1);
    check("R8 partial lost", seen, 0);

    // R4 filter v1 on every-cycle timebase
    start(1'b1, 1'b0, 2'd0, 4'd1);
    drive(1'b1, 1, 1'b1);
    drive(1'b0, 3, 1'b1);
    check("R4 one-tick glitch", seen, 0);
    drive(1'b1, 2, 1'b1);
    check("R4 two ticks accepted", seen, 1);
    drive(1'b1, 5, 1'b1);
    check("R4 held level single count", seen, 1);
    drive(1'b0, 2, 1'b1);
    drive(1'b1, 2, 1'b1);
    check("R4 second rise", seen, 2);

    // R5 restart
    start(1'b1, 1'b0, 2'd0, 4'd2);
    drive(1'b1, 3, 1'b0);
    drive(1'b1, 0, 1'b1);
    seen = 0;
    @(negedge clk_i);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i); pulse_i = 1'b1; tick_i = 4'h1;
    end
    @(negedge clk_i); pulse_i = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i); pulse_i = 1'b1;
    end
    @(negedge clk_i); tick_i = '0;
    repeat (2) @(negedge clk_i);
    check("R5 restart blocks count", seen, 0);
    drive(1'b1, 4, 1'b1);
    check("R5 four stable ticks", seen, 1);

    // R6 value 0 acts as 2
    start(1'b1, 1'b0, 2'd0, 4'd0);
    drive(1'b1, 1, 1'b1);
    drive(1'b0, 2, 1'b1);
    check("R6 one tick rejected", seen, 0);
    drive(1'b1, 2, 1'b1);
    check("R6 two ticks accepted", seen, 1);

    // R1 filter only sees selected source (every 4th cycle)
    start(1'b1, 1'b0, 2'd3, 4'd1);
    drive(1'b1, 4, 1'b1);
    drive(1'b0, 1, 1'b1);
    check("R1 filter one selected tick", seen, 0);
    drive(1'b1, 5, 1'b1);
    check("R1 filter two selected ticks", seen, 1);

    // R4 maximum filter
    start(1'b1, 1'b0, 2'd0, 4'd15);
    drive(1'b1, 32767, 1'b1);
    check("R4 v15 one short", seen, 0);
    drive(1'b1, 1, 1'b1);
    check("R4 v15 accepted", seen, 1);

    // R7 bypass counts raw edges, no ticks
    start(1'b1, 1'b1, 2'd0, 4'd5);
    for (int e = 0; e < 3; e++) begin
      drive(1'b1, 1, 1'b0);
      drive(1'b0, 2, 1'b0);
    end
    check("R7 raw rising edges", seen, 3);

    finish_run();
  end
endmodule